// File: doc/BRIEF.md
# Multi-Width Integer Divide Unit

A sequential integer divider for the execute stage of a 32-bit processor. One request covers three operand widths, each signed or unsigned: a 32-bit dividend over a 16-bit divisor ("word" mode), 32 bits over 32 bits ("long" mode), and a 64-bit dividend over 32 bits ("quad" mode). In quad mode the dividend is made from two register values. The remainder register supplies the upper half and the quotient register supplies the lower half.

The unit produces results that can be written straight into the register file. It also produces the four condition flags, a strobe that raises a divide-by-zero trap, and a write-enable pair for the quotient and remainder destinations. A quotient that does not fit its destination is reported through the overflow flag, and in that case nothing is written. Each request is launched with a single-cycle start strobe. The caller waits for a one-cycle valid pulse. The quotient is found one bit per cycle by a restoring loop that works on operand magnitudes. Signs are applied when the loop ends.

Top module: `intdiv_unit`

## Requirements
- R1: Mode code 2'b00 is word mode. Only divisor bits 15:0 are used, sign-extended when signed. The result word holds the remainder in bits 31:16 and the quotient in bits 15:0.
- R2: Mode code 2'b01 is long mode, and code 2'b11 behaves the same way. The 32-bit quotient appears on the quotient output and the 32-bit remainder appears on the remainder output.
- R3: Mode code 2'b10 is quad mode. The dividend is {remainder-register value, quotient-register value}, and the 32-bit quotient and remainder are returned as in R2.
- R4: A signed division truncates the quotient toward zero. The remainder takes the sign of the dividend.
- R5: Overflow occurs when the quotient exceeds the destination width. In word mode the limits are 0..0xFFFF unsigned and -32768..32767 signed. In long and quad modes the limits are the 32-bit unsigned or signed range. On overflow V=1, N equals the n_prev input, Z=0, and neither write enable is raised.
- R6: A zero divisor (bits 15:0 in word mode, all 32 bits otherwise) pulses div0 together with valid. Nothing is written, C=0, V=0, Z=0, and N equals n_prev.
- R7: C is 0 on every result. V is 0 on every result that neither overflows nor divides by zero.
- R8: On a normal result N is the sign bit of the quotient and Z is set when the quotient is zero. In word mode the quotient is taken as a 16-bit value.
- R9: A normal word result raises only the quotient write. A normal long or quad result raises both writes. When same_dst is set, it raises only the quotient write, so the quotient is the value left in the shared register.
- R10: Valid rises on the 17th rising edge after the edge that accepts start for a normal word result, and on the 33rd edge for long and quad. A zero divisor reports on the 1st edge.
- R11: Busy is high from the accepting edge until valid. A start pulse seen while busy is ignored, and operand inputs may change after the accepting edge without effect.
- R12: After reset busy, valid, div0 and both write enables are low. Valid is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted while idle |
| mode_i | input | 2 | 00 word, 01/11 long, 10 quad |
| sgn_i | input | 1 | Signed division when high |
| quo_reg_i | input | 32 | Quotient-register value (dividend, low half in quad mode) |
| rem_reg_i | input | 32 | Remainder-register value (dividend high half in quad mode) |
| divisor_i | input | 32 | Divisor |
| same_dst_i | input | 1 | Quotient and remainder destinations are the same register |
| n_prev_i | input | 1 | Current N flag, kept on overflow or divide by zero |
| busy_o | output | 1 | Division in progress |
| valid_o | output | 1 | One-cycle result strobe |
| div0_o | output | 1 | Divide-by-zero trap strobe |
| wr_quo_o | output | 1 | Write quotient destination |
| wr_rem_o | output | 1 | Write remainder destination |
| quo_data_o | output | 32 | Quotient, or packed remainder:quotient in word mode |
| rem_data_o | output | 32 | Remainder in long and quad modes |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag |

## Verification
The hardest cases to reach are the signed quotients that sit exactly at the edge of the destination range. A magnitude of 0x8000 is legal when the quotient is negative and an overflow when it is positive, and 2^31 behaves the same way in quad mode. Both cases pass the start-time magnitude test and are caught only after the final iteration. The sweeps cross dividends such as 0x80000000, 0xFFFF8000 and 0x7FFFFFFF with divisors of 1, -1, 0x8000 and 0xFFFF in both signednesses. The quad sweep pairs upper halves 0x80000000 and 0xFFFFFFFF with divisors of -1. Every such combination is checked against plain 64-bit magnitude arithmetic.

// File: rtl/intdiv_pkg.sv
package intdiv_pkg;

    typedef enum logic [1:0] {
        DS_IDLE = 2'd0,
        DS_RUN  = 2'd1,
        DS_FIN  = 2'd2
    } div_state_e;

    typedef enum logic [1:0] {
        DK_OK   = 2'd0,
        DK_OVF  = 2'd1,
        DK_ZERO = 2'd2
    } div_kind_e;

    localparam logic [1:0] MODE_WORD = 2'b00;
    localparam logic [1:0] MODE_LONG = 2'b01;
    localparam logic [1:0] MODE_QUAD = 2'b10;

endpackage

// File: rtl/intdiv_prep.sv
// Operand conditioning: magnitudes, result signs, start-time checks and
// initial partial remainder / shift register for the restoring loop.
module intdiv_prep
    import intdiv_pkg::*;
#(
    parameter  int XLEN = 32,
    localparam int HALF = XLEN / 2,
    localparam int CW   = $clog2(XLEN) + 1
) (
    input  logic [1:0]      mode_i,
    input  logic            sgn_i,
    input  logic [XLEN-1:0] lo_i,
    input  logic [XLEN-1:0] hi_i,
    input  logic [XLEN-1:0] dvs_i,
    output logic [XLEN-1:0] dvs_mag_o,
    output logic [XLEN-1:0] p_init_o,
    output logic [XLEN-1:0] q_init_o,
    output logic [CW-1:0]   iters_o,
    output logic            neg_q_o,
    output logic            neg_r_o,
    output logic            zero_o,
    output logic            pre_ovf_o
);
    logic              is_word, is_quad, dvs_neg, dend_neg;
    logic [XLEN-1:0]   dvs_ext;
    logic [2*XLEN-1:0] dend, dend_mag;

    always_comb begin
        is_word   = (mode_i == MODE_WORD);
        is_quad   = (mode_i == MODE_QUAD);
        dvs_ext   = is_word ? {{(XLEN-HALF){sgn_i & dvs_i[HALF-1]}}, dvs_i[HALF-1:0]} : dvs_i;
        dvs_neg   = sgn_i & dvs_ext[XLEN-1];
        dvs_mag_o = dvs_neg ? (~dvs_ext + 1'b1) : dvs_ext;
        dend      = is_quad ? {hi_i, lo_i} : {{XLEN{sgn_i & lo_i[XLEN-1]}}, lo_i};
        dend_neg  = sgn_i & dend[2*XLEN-1];
        dend_mag  = dend_neg ? (~dend + 1'b1) : dend;
        if (is_word) begin
            p_init_o = {{(XLEN-HALF){1'b0}}, dend_mag[XLEN-1:HALF]};
            q_init_o = {dend_mag[HALF-1:0], {HALF{1'b0}}};
            iters_o  = CW'(HALF);
        end else if (is_quad) begin
            p_init_o = dend_mag[2*XLEN-1:XLEN];
            q_init_o = dend_mag[XLEN-1:0];
            iters_o  = CW'(XLEN);
        end else begin
            p_init_o = '0;
            q_init_o = dend_mag[XLEN-1:0];
            iters_o  = CW'(XLEN);
        end
        // Upper part not below divisor: quotient magnitude cannot fit
        pre_ovf_o = (p_init_o >= dvs_mag_o);
        zero_o    = (dvs_ext == '0);
        neg_q_o   = dend_neg ^ dvs_neg;
        neg_r_o   = dend_neg;
    end

endmodule

// File: rtl/intdiv_step.sv
// One restoring-division iteration: shift in a dividend bit, trial subtract.
module intdiv_step #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] p_i,
    input  logic [XLEN-1:0] q_i,
    input  logic [XLEN-1:0] dvs_i,
    output logic [XLEN-1:0] p_o,
    output logic [XLEN-1:0] q_o
);
    logic [XLEN:0] trial, diff;
    logic          fits;

    always_comb begin
        trial = {p_i, q_i[XLEN-1]};
        diff  = trial - {1'b0, dvs_i};
        fits  = (trial >= {1'b0, dvs_i});
        p_o   = fits ? diff[XLEN-1:0] : trial[XLEN-1:0];
        q_o   = {q_i[XLEN-2:0], fits};
    end

endmodule

// File: rtl/intdiv_unit.sv
module intdiv_unit
    import intdiv_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            start_i,
    input  logic [1:0]      mode_i,
    input  logic            sgn_i,
    input  logic [XLEN-1:0] quo_reg_i,
    input  logic [XLEN-1:0] rem_reg_i,
    input  logic [XLEN-1:0] divisor_i,
    input  logic            same_dst_i,
    input  logic            n_prev_i,
    output logic            busy_o,
    output logic            valid_o,
    output logic            div0_o,
    output logic            wr_quo_o,
    output logic            wr_rem_o,
    output logic [XLEN-1:0] quo_data_o,
    output logic [XLEN-1:0] rem_data_o,
    output logic            flag_n_o,
    output logic            flag_z_o,
    output logic            flag_v_o,
    output logic            flag_c_o
);
    localparam int HALF = XLEN / 2;
    localparam int CW   = $clog2(XLEN) + 1;

    typedef struct packed {
        div_state_e      st;
        logic [CW-1:0]   cnt;
        logic [XLEN-1:0] p;
        logic [XLEN-1:0] q;
        logic [XLEN-1:0] dvs;
        logic            word;
        logic            sgn;
        logic            neg_q;
        logic            neg_r;
        logic            same;
        logic            n_prev;
        div_kind_e       kind;
        logic            valid;
        logic            div0;
        logic            wr_q;
        logic            wr_r;
        logic [XLEN-1:0] res_q;
        logic [XLEN-1:0] res_r;
        logic            fn;
        logic            fz;
        logic            fv;
    } div_regs_t;

    div_regs_t r_d, r_q;

    logic [XLEN-1:0] prep_dvs, prep_p, prep_q, step_p, step_q;
    logic [CW-1:0]   prep_iters;
    logic            prep_negq, prep_negr, prep_zero, prep_ovf;
    logic [XLEN-1:0] qmag, qsgn, rsgn, lim;
    logic            post_ovf;

    intdiv_prep #(.XLEN(XLEN)) u_prep (
        .mode_i    (mode_i),
        .sgn_i     (sgn_i),
        .lo_i      (quo_reg_i),
        .hi_i      (rem_reg_i),
        .dvs_i     (divisor_i),
        .dvs_mag_o (prep_dvs),
        .p_init_o  (prep_p),
        .q_init_o  (prep_q),
        .iters_o   (prep_iters),
        .neg_q_o   (prep_negq),
        .neg_r_o   (prep_negr),
        .zero_o    (prep_zero),
        .pre_ovf_o (prep_ovf)
    );

    intdiv_step #(.XLEN(XLEN)) u_step (
        .p_i   (r_q.p),
        .q_i   (r_q.q),
        .dvs_i (r_q.dvs),
        .p_o   (step_p),
        .q_o   (step_q)
    );

    always_comb begin
        qmag     = r_q.word ? {{(XLEN-HALF){1'b0}}, r_q.q[HALF-1:0]} : r_q.q;
        qsgn     = r_q.neg_q ? (~qmag + 1'b1) : qmag;
        rsgn     = r_q.neg_r ? (~r_q.p + 1'b1) : r_q.p;
        lim      = r_q.word ? (XLEN'(1) << (HALF-1)) : (XLEN'(1) << (XLEN-1));
        post_ovf = r_q.sgn & (r_q.neg_q ? (qmag > lim) : (qmag >= lim));

        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.div0  = 1'b0;
        r_d.wr_q  = 1'b0;
        r_d.wr_r  = 1'b0;
        unique case (r_q.st)
            DS_IDLE: begin
                if (start_i) begin
                    r_d.p      = prep_p;
                    r_d.q      = prep_q;
                    r_d.dvs    = prep_dvs;
                    r_d.cnt    = prep_iters;
                    r_d.word   = (mode_i == MODE_WORD);
                    r_d.sgn    = sgn_i;
                    r_d.neg_q  = prep_negq;
                    r_d.neg_r  = prep_negr;
                    r_d.same   = same_dst_i;
                    r_d.n_prev = n_prev_i;
                    if (prep_zero) begin
                        r_d.kind = DK_ZERO;
                        r_d.st   = DS_FIN;
                    end else if (prep_ovf) begin
                        r_d.kind = DK_OVF;
                        r_d.st   = DS_FIN;
                    end else begin
                        r_d.kind = DK_OK;
                        r_d.st   = DS_RUN;
                    end
                end
            end
            DS_RUN: begin
                r_d.p   = step_p;
                r_d.q   = step_q;
                r_d.cnt = r_q.cnt - 1'b1;
                if (r_q.cnt == CW'(1)) r_d.st = DS_FIN;
            end
            DS_FIN: begin
                r_d.st    = DS_IDLE;
                r_d.valid = 1'b1;
                if (r_q.kind == DK_ZERO || r_q.kind == DK_OVF || post_ovf) begin
                    r_d.div0  = (r_q.kind == DK_ZERO);
                    r_d.fv    = (r_q.kind != DK_ZERO);
                    r_d.fn    = r_q.n_prev;
                    r_d.fz    = 1'b0;
                    r_d.res_q = '0;
                    r_d.res_r = '0;
                end else if (r_q.word) begin
                    r_d.res_q = {rsgn[HALF-1:0], qsgn[HALF-1:0]};
                    r_d.res_r = '0;
                    r_d.fn    = qsgn[HALF-1];
                    r_d.fz    = (qsgn[HALF-1:0] == '0);
                    r_d.fv    = 1'b0;
                    r_d.wr_q  = 1'b1;
                end else begin
                    r_d.res_q = qsgn;
                    r_d.res_r = rsgn;
                    r_d.fn    = qsgn[XLEN-1];
                    r_d.fz    = (qsgn == '0);
                    r_d.fv    = 1'b0;
                    r_d.wr_q  = 1'b1;
                    r_d.wr_r  = !r_q.same;
                end
            end
            default: r_d.st = DS_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign busy_o     = (r_q.st != DS_IDLE);
    assign valid_o    = r_q.valid;
    assign div0_o     = r_q.div0;
    assign wr_quo_o   = r_q.wr_q;
    assign wr_rem_o   = r_q.wr_r;
    assign quo_data_o = r_q.res_q;
    assign rem_data_o = r_q.res_r;
    assign flag_n_o   = r_q.fn;
    assign flag_z_o   = r_q.fz;
    assign flag_v_o   = r_q.fv;
    assign flag_c_o   = 1'b0;

    a_r6_div0_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div0_o |-> (valid_o && !wr_quo_o && !wr_rem_o && !flag_v_o))
        else $error("div0 strobe with a write or without valid");

    a_r5_ovf_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && flag_v_o) |-> (!wr_quo_o && !wr_rem_o && !flag_z_o))
        else $error("overflow result wrote a register");

    a_r9_quotient_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_rem_o |-> wr_quo_o)
        else $error("remainder written without quotient");

    a_r12_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o)
        else $error("valid held longer than one cycle");

    a_r11_idle_at_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> !busy_o)
        else $error("busy still high with valid");

    a_r11_run_holds_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !valid_o && r_q.st == DS_RUN) |=> (busy_o || valid_o))
        else $error("iteration dropped busy without result");

endmodule

// File: tb/intdiv_unit_tb_top.sv
module intdiv_unit_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic        sgn_i = 1'b0;
    logic [31:0] quo_reg_i = '0, rem_reg_i = '0, divisor_i = '0;
    logic        same_dst_i = 1'b0, n_prev_i = 1'b0;
    logic        busy_o, valid_o, div0_o, wr_quo_o, wr_rem_o;
    logic [31:0] quo_data_o, rem_data_o;
    logic        flag_n_o, flag_z_o, flag_v_o, flag_c_o;

    int vectors = 0;
    int miscompares = 0;

    always #2.5 clk_i = ~clk_i;

    intdiv_unit dut_i (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pick(input int i);
        case (i)
            0: return 32'h0;          1: return 32'h1;
            2: return 32'h5;          3: return 32'h64;
            4: return 32'h7FFF;       5: return 32'h8000;
            6: return 32'hFFFF;       7: return 32'h12345;
            8: return 32'hFFFFFFFF;   9: return 32'hFFFFFF9C;
            10: return 32'h80000000;  11: return 32'h7FFFFFFF;
            12: return 32'hFFFF8000;
            default: return ((32'(i) * 32'h9E3779B9) ^ 32'h5BD1E995) >> (i % 24);
        endcase
    endfunction

    function automatic logic [31:0] pick_dv(input int j);
        case (j)
            0: return 32'h0;         1: return 32'h1;
            2: return 32'h2;         3: return 32'h3;
            4: return 32'h7;         5: return 32'h7FFF;
            6: return 32'h8000;      7: return 32'hFFFF;
            8: return 32'hFFFE;      9: return 32'h100;
            10: return 32'h1234;     11: return 32'hFF00;
            12: return 32'hFFFFFFFF; default: return 32'h80000000;
        endcase
    endfunction

    task automatic run_one(input logic [1:0] md, input logic sg, input logic [31:0] lo,
                           input logic [31:0] hi, input logic [31:0] dv,
                           input logic sm, input logic np);
        logic [63:0] dend, dvx, dm, vm, qm, rm, plim, nlim, qv, rv, eq;
        logic dn, vn, qn, zero, ovf, en, ez, is_word, is_quad;
        int w, n, en_lat;
        is_word = (md == 2'b00);
        is_quad = (md == 2'b10);
        dend = is_quad ? {hi, lo} : (sg ? {{32{lo[31]}}, lo} : {32'h0, lo});
        dvx  = is_word ? (sg ? {{48{dv[15]}}, dv[15:0]} : {48'h0, dv[15:0]})
                       : (sg ? {{32{dv[31]}}, dv} : {32'h0, dv});
        dn = sg & dend[63];
        vn = sg & dvx[63];
        dm = dn ? -dend : dend;
        vm = vn ? -dvx : dvx;
        zero = (vm == 0);
        qm = zero ? 64'h0 : dm / vm;
        rm = zero ? 64'h0 : dm % vm;
        w = is_word ? 16 : 32;
        plim = sg ? (64'h1 << (w - 1)) - 1 : (64'h1 << w) - 1;
        nlim = 64'h1 << (w - 1);
        qn = dn ^ vn;
        ovf = !zero && ((sg && qn) ? (qm > nlim) : (qm > plim));
        qv = qn ? -qm : qm;
        rv = dn ? -rm : rm;
        if (is_word) begin
            eq = {32'h0, rv[15:0], qv[15:0]};
            en = qv[15];
            ez = (qv[15:0] == 0);
        end else begin
            eq = {32'h0, qv[31:0]};
            en = qv[31];
            ez = (qv[31:0] == 0);
        end
        en_lat = zero ? 1 : (is_word ? 17 : 33);

        @(negedge clk_i);
        mode_i = md; sgn_i = sg; quo_reg_i = lo; rem_reg_i = hi; divisor_i = dv;
        same_dst_i = sm; n_prev_i = np; start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        // operands change after acceptance: must not matter (R11)
        quo_reg_i = ~lo; rem_reg_i = ~hi; divisor_i = ~dv; n_prev_i = ~np; same_dst_i = ~sm;
        chk(busy_o == 1'b1, "R11 busy after start", 64'(busy_o), 64'h1);
        n = 0;
        while (!valid_o && n < 100) begin
            @(negedge clk_i);
            n++;
        end
        chk(valid_o == 1'b1, "R10 valid arrives", 64'(valid_o), 64'h1);
        chk(flag_c_o == 1'b0, "R7 carry clear", 64'(flag_c_o), 64'h0);
        if (zero) begin
            chk(n == en_lat, "R10 div0 latency", 64'(n), 64'(en_lat));
            chk(div0_o == 1'b1, "R6 trap strobe", 64'(div0_o), 64'h1);
            chk({wr_quo_o, wr_rem_o} == 2'b00, "R6 no write", 64'({wr_quo_o, wr_rem_o}), 64'h0);
            chk({flag_n_o, flag_z_o, flag_v_o} == {np, 2'b00}, "R6 flags",
                64'({flag_n_o, flag_z_o, flag_v_o}), 64'({np, 2'b00}));
        end else if (ovf) begin
            chk(div0_o == 1'b0, "R5 no trap", 64'(div0_o), 64'h0);
            chk({wr_quo_o, wr_rem_o} == 2'b00, "R5 no write", 64'({wr_quo_o, wr_rem_o}), 64'h0);
            chk({flag_n_o, flag_z_o, flag_v_o} == {np, 2'b01}, "R5 flags",
                64'({flag_n_o, flag_z_o, flag_v_o}), 64'({np, 2'b01}));
        end else begin
            chk(n == en_lat, "R10 latency", 64'(n), 64'(en_lat));
            chk(div0_o == 1'b0, "R6 no trap", 64'(div0_o), 64'h0);
            chk(64'(quo_data_o) == eq, is_word ? "R1 packed word result" :
                (is_quad ? "R3 quad quotient" : "R2 long quotient"), 64'(quo_data_o), eq);
            if (!is_word)
                chk(rem_data_o == rv[31:0], sg ? "R4 signed remainder" : "R2 remainder",
                    64'(rem_data_o), {32'h0, rv[31:0]});
            chk({flag_n_o, flag_z_o} == {en, ez}, "R8 N/Z", 64'({flag_n_o, flag_z_o}), 64'({en, ez}));
            chk(flag_v_o == 1'b0, "R7 V clear", 64'(flag_v_o), 64'h0);
            chk({wr_quo_o, wr_rem_o} == {1'b1, !is_word && !sm}, "R9 write mask",
                64'({wr_quo_o, wr_rem_o}), 64'({1'b1, !is_word && !sm}));
        end
        @(negedge clk_i);
        chk(valid_o == 1'b0, "R12 valid pulse", 64'(valid_o), 64'h0);
    endtask

    initial begin
        repeat (190000) @(posedge clk_i);
        miscompares++;
        $display("FAIL R10 watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int n, extra;
        repeat (3) @(negedge clk_i);
        chk({busy_o, valid_o, div0_o, wr_quo_o, wr_rem_o} == 5'b0, "R12 reset state",
            64'({busy_o, valid_o, div0_o, wr_quo_o, wr_rem_o}), 64'h0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        chk({busy_o, valid_o} == 2'b0, "R12 idle after reset", 64'({busy_o, valid_o}), 64'h0);

        // R1 word modes, divisor upper half garbage
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 24; i++)
                for (int j = 0; j < 14; j++)
                    run_one(2'b00, s[0], pick(i), 32'hDEAD0000, {16'hA5C3, pick_dv(j)[15:0]},
                            1'b0, (i + j) % 2 == 1);
        // R2 long modes, code 11 aliased
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 20; i++)
                for (int j = 0; j < 14; j++)
                    run_one((i % 5 == 4) ? 2'b11 : 2'b01, s[0], pick(i), 32'h0, pick_dv(j),
                            (j % 3 == 0), (i % 2 == 1));
        // R3 quad mode
        for (int s = 0; s < 2; s++)
            for (int h = 0; h < 6; h++)
                for (int i = 0; i < 8; i++)
                    for (int j = 0; j < 14; j++) begin
                        logic [31:0] hv;
                        case (h)
                            0: hv = 32'h0;        1: hv = 32'h1;
                            2: hv = 32'h123;      3: hv = 32'hFFFFFFFF;
                            4: hv = 32'hFFFFFF00; default: hv = 32'h80000000;
                        endcase
                        run_one(2'b10, s[0], pick(i + 5), hv, pick_dv(j), (j % 4 == 1), (j % 2 == 0));
                    end

        // R11 start while busy ignored: 100/7 word unsigned -> {0002,000E}
        @(negedge clk_i);
        mode_i = 2'b00; sgn_i = 1'b0; quo_reg_i = 32'd100; divisor_i = 32'd7; start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        @(negedge clk_i);
        mode_i = 2'b01; quo_reg_i = 32'd1000; divisor_i = 32'd3; start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        n = 2;
        while (!valid_o && n < 100) begin
            @(negedge clk_i);
            n++;
        end
        chk(n == 17, "R11 latency unaffected by second start", 64'(n), 64'd17);
        chk(quo_data_o == 32'h0002000E, "R11 first request result kept", 64'(quo_data_o), 64'h0002000E);
        extra = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk_i);
            if (valid_o || busy_o) extra++;
        end
        chk(extra == 0, "R11 ignored start left no work", 64'(extra), 64'h0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule